// File: doc/BRIEF.md
# Radio Task/Event Sequencer with Shortcut Chaining

This block is the control core of a packet radio. Software, or any other agent, fires single-cycle task pulses: transmit enable, receive enable, start, stop, disable and channel-assessment start. The block walks a state machine through ramp-up, idle, active and shut-down phases, and it reports progress as sticky event flags. Ramp-up and shut-down last a fixed number of cycles set by parameters. The end of a packet and the result of a channel assessment arrive on input pins, so the surrounding logic or a bench decides when they happen.

A shortcut vector lets chosen events fire chosen tasks one clock later without any software in the loop. With the right shortcuts set, a single disable task runs the whole sequence: shut-down, then receive ramp, then channel assessment, then transmit ramp when the channel is clear. A separate enable register, written through set and clear masks, gates the event flags onto one interrupt line.

Top module: `radio_sequencer`

## Requirements
- R1: After reset the state is DISABLED, and all event flags, all interrupt enables and the interrupt line are 0. The 4-bit state output uses these codes: DISABLED=0, RXRU=1, RXIDLE=2, RX=3, RXDISABLE=4, TXRU=9, TXIDLE=10, TX=11, TXDISABLE=12.
- R2: Receive enable in DISABLED enters RXRU. After exactly RAMP_CYC cycles the block enters RXIDLE and sets READY (bit 0) and RXREADY (bit 22).
- R3: Transmit enable in DISABLED or RXIDLE enters TXRU. After RAMP_CYC cycles the block enters TXIDLE and sets READY and TXREADY (bit 21). Start in RXIDLE enters RX, and start in TXIDLE enters TX. A pulse on pkt_end_i in RX or TX sets END (bit 3) and returns the block to the matching idle state.
- R4: Disable from any ramp, idle or active state enters RXDISABLE or TXDISABLE, according to the side the block is on. After DIS_CYC cycles the block enters DISABLED and sets DISABLED (bit 4).
- R5: A task that is not legal in the current state is ignored and raises no event. This includes start, stop, channel-assessment start and disable while DISABLED, and receive enable while RXIDLE.
- R6: Channel-assessment start is accepted in RXIDLE. The next cca_done_i then sets CCAIDLE (bit 17) when cca_busy_i is 0 and CCABUSY (bit 18) when it is 1. The state stays RXIDLE, and a busy result never leads to a transmit ramp.
- R7: Event flags stay set until the matching bit of evt_clr_i is pulsed, including flags whose event a shortcut has already used. If an event and its clear arrive in the same cycle, the event wins.
- R8: Shortcut bits map as follows: bit 0 READY→start, bit 1 END→disable, bit 2 DISABLED→transmit enable, bit 3 DISABLED→receive enable, bit 11 RXREADY→assessment start, bit 12 CCAIDLE→transmit enable, bit 19 TXREADY→start. The triggered task takes effect on the clock after the edge that raised the event.
- R9: With shortcut bits 3, 11 and 12 set, one disable task from RXIDLE runs shut-down, receive ramp and assessment start. A clear result then leads to transmit ramp and TXIDLE with no further task input.
- R10: Each set in int_set_i sets its interrupt-enable bit and each set in int_clr_i clears it, with set winning. irq_o is the OR of the event flags ANDed with the enables, delayed one cycle when IRQ_REG=1.
- R11: Stop in RX or TX returns the block to the matching idle state without setting END.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| task_txen_i | input | 1 | Transmit enable task pulse |
| task_rxen_i | input | 1 | Receive enable task pulse |
| task_start_i | input | 1 | Start task pulse |
| task_stop_i | input | 1 | Stop task pulse |
| task_disable_i | input | 1 | Disable task pulse |
| task_cca_i | input | 1 | Channel-assessment start task pulse |
| pkt_end_i | input | 1 | Packet finished while RX or TX |
| cca_done_i | input | 1 | Channel assessment finished |
| cca_busy_i | input | 1 | Assessment result, 1 = busy, read with cca_done_i |
| shorts_i | input | 20 | Shortcut enables |
| evt_clr_i | input | 23 | Per-bit event flag clear pulses |
| int_set_i | input | 23 | Per-bit interrupt-enable set pulses |
| int_clr_i | input | 23 | Per-bit interrupt-enable clear pulses |
| state_o | output | 4 | Current state code |
| events_o | output | 23 | Sticky event flags |
| int_en_o | output | 23 | Interrupt-enable register |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with RAMP_CYC=3, DIS_CYC=2 and IRQ_REG=1. These short ramp and shut-down windows make exact cycle counts on each phase boundary cheap to check, including the full shortcut chain from disable to TXIDLE. The registered interrupt variant adds a one-cycle lag, and the randomized enable and clear traffic is checked against that lag.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;
   typedef enum logic [3:0] {
      ST_OFF     = 4'd0,
      ST_RX_RAMP = 4'd1,
      ST_RX_IDLE = 4'd2,
      ST_RX_ACT  = 4'd3,
      ST_RX_DIS  = 4'd4,
      ST_TX_RAMP = 4'd9,
      ST_TX_IDLE = 4'd10,
      ST_TX_ACT  = 4'd11,
      ST_TX_DIS  = 4'd12
   } rs_state_e;

   localparam int NTASK      = 6;
   localparam int TK_TXEN    = 0;
   localparam int TK_RXEN    = 1;
   localparam int TK_START   = 2;
   localparam int TK_STOP    = 3;
   localparam int TK_DISABLE = 4;
   localparam int TK_CCA     = 5;

   localparam int EV_W        = 23;
   localparam int EV_READY    = 0;
   localparam int EV_END      = 3;
   localparam int EV_DISABLED = 4;
   localparam int EV_CCAIDLE  = 17;
   localparam int EV_CCABUSY  = 18;
   localparam int EV_TXREADY  = 21;
   localparam int EV_RXREADY  = 22;

   localparam int SC_W = 20;
   localparam int NSC  = 7;
   localparam int SC_BIT [NSC] = '{0, 1, 2, 3, 11, 12, 19};
   localparam int SC_EV  [NSC] = '{EV_READY, EV_END, EV_DISABLED, EV_DISABLED,
                                   EV_RXREADY, EV_CCAIDLE, EV_TXREADY};
   localparam int SC_TK  [NSC] = '{TK_START, TK_DISABLE, TK_TXEN, TK_RXEN,
                                   TK_CCA, TK_TXEN, TK_START};
endpackage

// File: rtl/radio_seq_dwell.sv
module radio_seq_dwell #(
   parameter int CNT_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cnt_o <= '0;
      else if (restart_i)          cnt_o <= '0;
      else if (cnt_o != CNT_MAX)   cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/radio_seq_shortcuts.sv
module radio_seq_shortcuts
   import radio_seq_pkg::*;
(
   input  logic [SC_W-1:0]  shorts_i,
   input  logic [EV_W-1:0]  fired_i,
   output logic [NTASK-1:0] task_o
);
   logic [NSC-1:0] hit;

   for (genvar k = 0; k < NSC; k++) begin : g_sc
      assign hit[k] = shorts_i[SC_BIT[k]] & fired_i[SC_EV[k]];
   end

   always_comb begin
      task_o = '0;
      for (int k = 0; k < NSC; k++) begin
         if (hit[k]) task_o[SC_TK[k]] = 1'b1;
      end
   end

   logic unused_bits;
   assign unused_bits = &{1'b0, shorts_i, fired_i};
endmodule

// File: rtl/radio_seq_fsm.sv
module radio_seq_fsm
   import radio_seq_pkg::*;
#(
   parameter int RAMP_CYC = 4,
   parameter int DIS_CYC  = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NTASK-1:0] task_i,
   input  logic             pkt_end_i,
   input  logic             cca_done_i,
   input  logic             cca_busy_i,
   output rs_state_e        state_o,
   output logic [EV_W-1:0]  new_ev_o
);
   localparam int DWELL_MAX = (RAMP_CYC > DIS_CYC) ? RAMP_CYC : DIS_CYC;
   localparam int CNT_W     = $clog2(DWELL_MAX + 1);
   localparam logic [CNT_W-1:0] RAMP_LAST = CNT_W'(RAMP_CYC - 1);
   localparam logic [CNT_W-1:0] DIS_LAST  = CNT_W'(DIS_CYC - 1);

   rs_state_e        state_q, state_d;
   logic             cca_q, cca_d;
   logic [CNT_W-1:0] cnt;
   logic             may_disable;

   radio_seq_dwell #(.CNT_W(CNT_W)) u_dwell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (state_d != state_q),
      .cnt_o     (cnt)
   );

   assign may_disable = task_i[TK_DISABLE] &&
                        (state_q inside {ST_RX_RAMP, ST_RX_IDLE, ST_RX_ACT,
                                         ST_TX_RAMP, ST_TX_IDLE, ST_TX_ACT});

   always_comb begin
      state_d  = state_q;
      cca_d    = cca_q;
      new_ev_o = '0;
      if (may_disable) begin
         state_d = (state_q inside {ST_TX_RAMP, ST_TX_IDLE, ST_TX_ACT}) ? ST_TX_DIS : ST_RX_DIS;
      end else begin
         unique case (state_q)
            ST_OFF: begin
               if (task_i[TK_TXEN])      state_d = ST_TX_RAMP;
               else if (task_i[TK_RXEN]) state_d = ST_RX_RAMP;
            end
            ST_RX_RAMP: if (cnt == RAMP_LAST) begin
               state_d               = ST_RX_IDLE;
               new_ev_o[EV_READY]    = 1'b1;
               new_ev_o[EV_RXREADY]  = 1'b1;
            end
            ST_RX_IDLE: begin
               if (cca_q && cca_done_i) begin
                  cca_d = 1'b0;
                  new_ev_o[EV_CCABUSY] = cca_busy_i;
                  new_ev_o[EV_CCAIDLE] = !cca_busy_i;
               end
               if (task_i[TK_TXEN])                state_d = ST_TX_RAMP;
               else if (task_i[TK_START])          state_d = ST_RX_ACT;
               else if (task_i[TK_CCA] && !cca_q)  cca_d   = 1'b1;
            end
            ST_RX_ACT: begin
               if (task_i[TK_STOP]) state_d = ST_RX_IDLE;
               else if (pkt_end_i) begin
                  state_d            = ST_RX_IDLE;
                  new_ev_o[EV_END]   = 1'b1;
               end
            end
            ST_TX_RAMP: if (cnt == RAMP_LAST) begin
               state_d               = ST_TX_IDLE;
               new_ev_o[EV_READY]    = 1'b1;
               new_ev_o[EV_TXREADY]  = 1'b1;
            end
            ST_TX_IDLE: if (task_i[TK_START]) state_d = ST_TX_ACT;
            ST_TX_ACT: begin
               if (task_i[TK_STOP]) state_d = ST_TX_IDLE;
               else if (pkt_end_i) begin
                  state_d            = ST_TX_IDLE;
                  new_ev_o[EV_END]   = 1'b1;
               end
            end
            ST_RX_DIS, ST_TX_DIS: if (cnt == DIS_LAST) begin
               state_d                = ST_OFF;
               new_ev_o[EV_DISABLED]  = 1'b1;
            end
            default: state_d = ST_OFF;
         endcase
      end
      if (state_d != ST_RX_IDLE) cca_d = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_OFF;
         cca_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cca_q   <= cca_d;
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/radio_seq_events.sv
module radio_seq_events
   import radio_seq_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [EV_W-1:0] new_ev_i,
   input  logic [EV_W-1:0] clr_i,
   input  logic [EV_W-1:0] en_set_i,
   input  logic [EV_W-1:0] en_clr_i,
   output logic [EV_W-1:0] flags_o,
   output logic [EV_W-1:0] en_o,
   output logic [EV_W-1:0] fired_o,
   output logic            irq_o
);
   logic irq_raw;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flags_o <= '0;
         en_o    <= '0;
         fired_o <= '0;
      end else begin
         flags_o <= (flags_o & ~clr_i) | new_ev_i;
         en_o    <= (en_o & ~en_clr_i) | en_set_i;
         fired_o <= new_ev_i;
      end
   end

   assign irq_raw = |(flags_o & en_o);

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_o <= 1'b0;
         else         irq_o <= irq_raw;
      end
   end else begin : g_irq_comb
      assign irq_o = irq_raw;
   end
endmodule

// File: rtl/radio_sequencer.sv
module radio_sequencer
   import radio_seq_pkg::*;
#(
   parameter int RAMP_CYC = 4,
   parameter int DIS_CYC  = 2,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            task_txen_i,
   input  logic            task_rxen_i,
   input  logic            task_start_i,
   input  logic            task_stop_i,
   input  logic            task_disable_i,
   input  logic            task_cca_i,
   input  logic            pkt_end_i,
   input  logic            cca_done_i,
   input  logic            cca_busy_i,
   input  logic [SC_W-1:0] shorts_i,
   input  logic [EV_W-1:0] evt_clr_i,
   input  logic [EV_W-1:0] int_set_i,
   input  logic [EV_W-1:0] int_clr_i,
   output logic [3:0]      state_o,
   output logic [EV_W-1:0] events_o,
   output logic [EV_W-1:0] int_en_o,
   output logic            irq_o
);
   if (RAMP_CYC < 1) begin : g_bad_ramp
      $error("RAMP_CYC must be at least 1");
   end
   if (DIS_CYC < 1) begin : g_bad_dis
      $error("DIS_CYC must be at least 1");
   end

   logic [NTASK-1:0] ext_task, sc_task, all_task;
   logic [EV_W-1:0]  new_ev, fired;
   rs_state_e        state;

   always_comb begin
      ext_task             = '0;
      ext_task[TK_TXEN]    = task_txen_i;
      ext_task[TK_RXEN]    = task_rxen_i;
      ext_task[TK_START]   = task_start_i;
      ext_task[TK_STOP]    = task_stop_i;
      ext_task[TK_DISABLE] = task_disable_i;
      ext_task[TK_CCA]     = task_cca_i;
   end
   assign all_task = ext_task | sc_task;

   radio_seq_shortcuts u_sc (
      .shorts_i (shorts_i),
      .fired_i  (fired),
      .task_o   (sc_task)
   );

   radio_seq_fsm #(.RAMP_CYC(RAMP_CYC), .DIS_CYC(DIS_CYC)) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .task_i     (all_task),
      .pkt_end_i  (pkt_end_i),
      .cca_done_i (cca_done_i),
      .cca_busy_i (cca_busy_i),
      .state_o    (state),
      .new_ev_o   (new_ev)
   );

   radio_seq_events #(.IRQ_REG(IRQ_REG)) u_ev (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .new_ev_i (new_ev),
      .clr_i    (evt_clr_i),
      .en_set_i (int_set_i),
      .en_clr_i (int_clr_i),
      .flags_o  (events_o),
      .en_o     (int_en_o),
      .fired_o  (fired),
      .irq_o    (irq_o)
   );

   assign state_o = state;
endmodule

// File: rtl/radio_sequencer_chk.sv
module radio_sequencer_chk #(
   parameter bit IRQ_REG = 1'b0
) (
   input logic        clk_i,
   input logic        rst_ni,
   input logic [3:0]  state_o,
   input logic [22:0] events_o,
   input logic [22:0] int_en_o,
   input logic [22:0] evt_clr_i,
   input logic        irq_o
);
   logic past_ok;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) past_ok <= 1'b0;
      else         past_ok <= 1'b1;
   end

   AST_STATE_ENCODED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_o inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd9, 4'd10, 4'd11, 4'd12}); // R1
   AST_RX_RAMP_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(state_o) == 4'd1 && state_o == 4'd2 |-> events_o[0] && events_o[22]); // R2
   AST_TX_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && state_o == 4'd11 && $past(state_o) != 4'd11 |-> $past(state_o) == 4'd10); // R3
   AST_DISABLED_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && state_o == 4'd0 && $past(state_o) != 4'd0 |-> events_o[4]); // R4
   AST_OFF_EXITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(state_o) == 4'd0 |-> state_o inside {4'd0, 4'd1, 4'd9}); // R5
   AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(events_o[0]) && !$past(evt_clr_i[0]) |-> events_o[0]); // R7

   if (IRQ_REG) begin : g_reg
      AST_IRQ_LAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         past_ok |-> irq_o == $past(|(events_o & int_en_o))); // R10
   end else begin : g_comb
      AST_IRQ_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o == |(events_o & int_en_o)); // R10
   end
endmodule

bind radio_sequencer radio_sequencer_chk #(.IRQ_REG(IRQ_REG)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .state_o   (state_o),
   .events_o  (events_o),
   .int_en_o  (int_en_o),
   .evt_clr_i (evt_clr_i),
   .irq_o     (irq_o)
);

// File: tb/radio_sequencer_tb.sv
`timescale 1ns/100ps
module radio_sequencer_tb_top;
   localparam int RAMP = 3;
   localparam int DIS  = 2;

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic [5:0]  tk = '0;   // txen, rxen, start, stop, disable, cca
   logic        pkt_end = 1'b0, cca_done = 1'b0, cca_busy = 1'b0;
   logic [19:0] shorts = '0;
   logic [22:0] evclr = '0, iset = '0, iclr = '0;
   logic [3:0]  state;
   logic [22:0] events, inten;
   logic        irq;
   int          nchk = 0, nfail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   radio_sequencer #(.RAMP_CYC(RAMP), .DIS_CYC(DIS), .IRQ_REG(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_ni),
      .task_txen_i(tk[0]), .task_rxen_i(tk[1]), .task_start_i(tk[2]),
      .task_stop_i(tk[3]), .task_disable_i(tk[4]), .task_cca_i(tk[5]),
      .pkt_end_i(pkt_end), .cca_done_i(cca_done), .cca_busy_i(cca_busy),
      .shorts_i(shorts), .evt_clr_i(evclr), .int_set_i(iset), .int_clr_i(iclr),
      .state_o(state), .events_o(events), .int_en_o(inten), .irq_o(irq));

   function automatic logic [22:0] en_next(logic [22:0] old, logic [22:0] s, logic [22:0] c);
      return (old & ~c) | s;
   endfunction
   function automatic logic irq_of(logic [22:0] f, logic [22:0] e);
      return |(f & e);
   endfunction

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask
   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask
   task automatic pulse(input int idx);
      tk[idx] = 1'b1; step(1); tk = '0;
   endtask
   task automatic clear_all();
      evclr = '1; step(1); evclr = '0;
   endtask
   task automatic cca_result(input logic busy);
      cca_done = 1'b1; cca_busy = busy; step(1); cca_done = 1'b0; cca_busy = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [22:0] fm, em, pf, pe;
      void'($urandom(32'd4242));
      step(3); rst_ni = 1'b1; step(1);
      // R1 reset state
      check("R1 state", state, 0);
      check("R1 events", events, 0);
      check("R1 inten", inten, 0);
      check("R1 irq", irq, 0);
      // R5 illegal tasks in DISABLED
      pulse(2); check("R5 start in off", state, 0);
      pulse(3); check("R5 stop in off", state, 0);
      pulse(5); check("R5 cca in off", state, 0);
      pulse(4); step(DIS + 1);
      check("R5 disable in off", state, 0);
      check("R5 no event", events, 0);
      // R2 receive ramp
      pulse(1); check("R2 rxru", state, 1);
      step(RAMP - 1); check("R2 still rxru", state, 1);
      step(1); check("R2 rxidle", state, 2);
      check("R2 ready+rxready", events, 23'h400001);
      pulse(1); check("R5 rxen in rxidle", state, 2);
      // R3 receive packet
      pulse(2); check("R3 rx", state, 3);
      pkt_end = 1'b1; step(1); pkt_end = 1'b0;
      check("R3 back to rxidle", state, 2);
      check("R3 end flag", events[3], 1);
      // R7 clear
      evclr = 23'h8; step(1); evclr = '0;
      check("R7 end cleared", events[3], 0);
      check("R7 others kept", events, 23'h400001);
      // R11 stop
      pulse(2); pulse(3);
      check("R11 stop to rxidle", state, 2);
      check("R11 no end", events[3], 0);
      // R6 assessment
      pulse(5); cca_result(1'b1);
      check("R6 busy flag", events[18], 1);
      check("R6 idle flag clear", events[17], 0);
      step(3); check("R6 stays rxidle", state, 2);
      pulse(5); cca_result(1'b0);
      check("R6 idle flag", events[17], 1);
      // R4 disable from rx side
      pulse(4); check("R4 rxdisable", state, 4);
      step(DIS - 1); check("R4 still rxdisable", state, 4);
      step(1); check("R4 disabled", state, 0);
      check("R4 disabled flag", events[4], 1);
      // R3 transmit side
      pulse(0); check("R3 txru", state, 9);
      step(RAMP); check("R3 txidle", state, 10);
      check("R3 txready", events[21], 1);
      pulse(2); check("R3 tx", state, 11);
      pulse(3); check("R11 tx stop", state, 10);
      pulse(4); check("R4 txdisable", state, 12);
      step(DIS); check("R4 off from tx", state, 0);
      clear_all(); check("R7 all cleared", events, 0);
      // R8 READY->START and END->DISABLE shortcuts
      shorts = 20'h1;
      pulse(1); step(RAMP); check("R8 rxidle", state, 2);
      step(1); check("R8 auto start", state, 3);
      check("R7 ready kept after shortcut", events[0], 1);
      shorts = 20'h2;
      pkt_end = 1'b1; step(1); pkt_end = 1'b0;
      check("R8 end to rxidle", state, 2);
      step(1); check("R8 auto disable", state, 4);
      step(DIS); check("R8 off", state, 0);
      // R7 set wins over clear
      shorts = '0; clear_all();
      pulse(1); step(RAMP - 1);
      evclr = 23'h1; step(1); evclr = '0;
      check("R7 set wins", events[0], 1);
      // R9 chain
      shorts = 20'h01808; clear_all();
      pulse(4); check("R9 rxdisable", state, 4);
      step(DIS); check("R9 disabled", state, 0);
      step(1); check("R9 auto rxen", state, 1);
      step(RAMP); check("R9 rxidle", state, 2);
      check("R9 rxready", events[22], 1);
      step(1); cca_result(1'b0);
      check("R9 ccaidle", events[17], 1);
      check("R9 pre tx ramp", state, 2);
      step(1); check("R9 auto txen", state, 9);
      step(RAMP); check("R9 txidle", state, 10);
      check("R9 txready", events[21], 1);
      pulse(2); check("R9 tx", state, 11);
      pkt_end = 1'b1; step(1); pkt_end = 1'b0;
      check("R9 end", events[3], 1);
      // R6 busy blocks transmit even with CCAIDLE->TXEN set
      clear_all();
      pulse(4); step(DIS + 1 + RAMP + 1);
      check("R6 chain rxidle", state, 2);
      cca_result(1'b1);
      check("R6 chain busy", events[18], 1);
      step(4); check("R6 no tx ramp", state, 2);
      // R10 randomized enable/clear traffic
      shorts = '0;
      fm = events; em = inten;
      for (int i = 0; i < 40; i++) begin
         pf = fm; pe = em;
         iset  = 23'($urandom) & 23'($urandom);
         iclr  = 23'($urandom);
         evclr = 23'($urandom) & 23'($urandom) & 23'($urandom);
         step(1);
         em = en_next(em, iset, iclr);
         fm = fm & ~evclr;
         iset = '0; iclr = '0; evclr = '0;
         check("R10 enable reg", inten, em);
         check("R7 flags after clear", events, fm);
         check("R10 irq", irq, irq_of(pf, pe));
      end
      // R10 directed: set and clear same bit, set wins
      iset = 23'h1; iclr = 23'h1; step(1); iset = '0; iclr = '0;
      check("R10 set wins", inten[0], 1);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule